// File: doc/BRIEF.md
# Keyboard Scan-Code Sequence Decoder

This block sits behind a serial keyboard receiver. It takes the stream of scan-code set 2 bytes that the receiver delivers, one byte per valid strobe. It folds each multi-byte make or break sequence into a single key event. An event carries four things: the final code byte, a flag that selects the normal or the extended key map, a flag that tells a key press from a key release, and a one-cycle valid strobe.

The sequence state is held in three flags:
- **pause flag**: the last byte other than a release prefix was the pause prefix 0xE1.
- **extended flag**: the machine is inside a sequence that began with 0xE0 or 0xE1.
- **release flag**: the last byte was the release prefix 0xF0.

Each incoming byte is sorted into a class by its upper bits, and the three flags are updated from that class. The pause sequence has an embedded 0x14 byte, and this byte is skipped. Events are registered, so they appear one cycle after the byte that completes them. Translation to characters and tracking of modifier keys belong to later logic.

Top module: `kbd_seq_decoder`

## Requirements
- R1: While rst_ni is low, the state is cleared and evt_vld_o is low. After reset is released, the first byte below 0x80 yields a normal-map make event.
- R2: In the idle state, a valid byte below 0x80 gives an event one cycle later with evt_vld_o=1, evt_code_o equal to the byte, evt_ext_o=0 and evt_brk_o=0.
- R3: The byte 0xF0 followed by a byte below 0x80 gives an event with evt_brk_o=1 and evt_ext_o=0.
- R4: After 0xE0, a byte below 0x80 gives an event with evt_ext_o=1 and evt_brk_o=0. After 0xE0 then 0xF0, it gives evt_ext_o=1 and evt_brk_o=1.
- R5: After 0xE1, the next byte below 0x80 is consumed without an event and leaves the machine in the extended state. The byte after that gives an event with evt_ext_o=1. The pause flag is never set while the extended flag is clear.
- R6: The sequence 0xE1, 0xF0, then a byte below 0x80 keeps the release flag. The next byte below 0x80 gives an event with evt_ext_o=1 and evt_brk_o=1.
- R7: Prefix bytes, meaning any byte with bit 7 set (including 0xE0, 0xE1 and 0xF0), never produce an event, so evt_vld_o is low in the following cycle.
- R8: A byte presented while byte_vld_i is low changes neither the state nor the outputs.
- R9: A byte from 0x80 to 0xBF produces no event. It clears the release and pause flags and keeps the extended flag.
- R10: evt_vld_o is high for exactly one cycle per event. After an event the machine is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received scan-code byte |
| byte_vld_i | input | 1 | byte_i holds a new byte this cycle |
| evt_vld_o | output | 1 | One-cycle key event strobe |
| evt_code_o | output | 8 | Final code byte of the event |
| evt_ext_o | output | 1 | 1 = extended key map, 0 = normal map |
| evt_brk_o | output | 1 | 1 = key release, 0 = key press |

## Verification
Every event is due exactly one clock edge after the byte that completes it. A prefix byte or a skipped byte must show evt_vld_o low at that same edge. The bench drives each byte on a falling edge and samples the event outputs on the next falling edge, which falls between that single register stage and the following edge. One cycle further on, it confirms that the strobe has dropped again. Checks that depend on state (idle hold, skipped pause byte, middle-class bytes) are read out through the code value and map/release flags of the next event.

// File: rtl/kbd_seq_pkg.sv
package kbd_seq_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned BIT_TOP   = CODE_W - 1;  // clear on plain key codes
  localparam int unsigned BIT_SUB   = CODE_W - 2;  // splits 0x80-0xBF from prefixes
  localparam int unsigned BIT_REL   = 4;           // release prefix vs extend prefix
  localparam int unsigned BIT_PAUSE = 0;           // 0xE1 vs 0xE0

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic e1;  // pause prefix seen
    logic e0;  // extended map
    logic f0;  // release pending
  } seq_state_t;

  typedef struct packed {
    logic low;      // plain key code
    logic hi;       // prefix range
    logic mid;      // 0x80-0xBF
    logic rel_pfx;  // release prefix class
    logic ext_pfx;  // extend prefix class
    logic pause;    // bit 0 of byte
  } byte_cls_t;

  localparam seq_state_t ST_IDLE = '0;
endpackage

// File: rtl/kbd_byte_class.sv
module kbd_byte_class
  import kbd_seq_pkg::*;
(
  input  code_t     byte_i,
  output byte_cls_t cls_o
);
  logic top_b, sub_b;

  always_comb begin
    top_b         = byte_i[BIT_TOP];
    sub_b         = byte_i[BIT_SUB];
    cls_o.low     = ~top_b;
    cls_o.hi      = top_b & sub_b;
    cls_o.mid     = top_b & ~sub_b;
    cls_o.rel_pfx = cls_o.hi & byte_i[BIT_REL];
    cls_o.ext_pfx = cls_o.hi & ~byte_i[BIT_REL];
    cls_o.pause   = byte_i[BIT_PAUSE];
  end
endmodule

// File: rtl/kbd_seq_fsm.sv
module kbd_seq_fsm
  import kbd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  byte_cls_t  cls_i,
  output seq_state_t st_o,
  output logic       emit_o
);
  seq_state_t st_q, st_d;
  logic       norm_b;

  always_comb begin
    norm_b  = ~st_q.e1 & cls_i.low;
    st_d.f0 = cls_i.rel_pfx | (st_q.e1 & cls_i.low & st_q.f0);  // skip keeps release
    st_d.e1 = cls_i.hi & (st_q.e1 | (cls_i.ext_pfx & cls_i.pause));
    st_d.e0 = st_q.e1 | (~norm_b & (st_q.e0 | cls_i.ext_pfx));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= ST_IDLE;
    else if (vld_i) st_q <= st_d;
  end

  assign st_o   = st_q;
  assign emit_o = vld_i & cls_i.low & ~st_q.e1;

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(st_q));
  p_no_unused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.e1 |-> st_q.e0);
  p_rel_sets_f0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cls_i.rel_pfx |=> st_q.f0);
  p_emit_to_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |=> (st_q == ST_IDLE));
  p_mid_keeps_e0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cls_i.mid |=> !st_q.f0 && !st_q.e1 && (st_q.e0 == $past(st_q.e0)));
endmodule

// File: rtl/kbd_evt_reg.sv
module kbd_evt_reg
  import kbd_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  emit_i,
  input  code_t code_i,
  input  logic  ext_i,
  input  logic  brk_i,
  output logic  evt_vld_o,
  output code_t evt_code_o,
  output logic  evt_ext_o,
  output logic  evt_brk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_vld_o  <= 1'b0;
      evt_code_o <= '0;
      evt_ext_o  <= 1'b0;
      evt_brk_o  <= 1'b0;
    end else begin
      evt_vld_o <= emit_i;
      if (emit_i) begin
        evt_code_o <= code_i;
        evt_ext_o  <= ext_i;
        evt_brk_o  <= brk_i;
      end
    end
  end

  p_evt_code_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld_o |-> !evt_code_o[BIT_TOP]);
  p_emit_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |=> evt_vld_o && (evt_code_o == $past(code_i)));
endmodule

// File: rtl/kbd_seq_decoder.sv
module kbd_seq_decoder
  import kbd_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic              evt_vld_o,
  output logic [CODE_W-1:0] evt_code_o,
  output logic              evt_ext_o,
  output logic              evt_brk_o
);
  byte_cls_t  cls;
  seq_state_t st;
  logic       emit;

  kbd_byte_class u_cls (
    .byte_i (byte_i),
    .cls_o  (cls)
  );

  kbd_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (byte_vld_i),
    .cls_i  (cls),
    .st_o   (st),
    .emit_o (emit)
  );

  kbd_evt_reg u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .emit_i     (emit),
    .code_i     (byte_i),
    .ext_i      (st.e0),
    .brk_i      (st.f0),
    .evt_vld_o  (evt_vld_o),
    .evt_code_o (evt_code_o),
    .evt_ext_o  (evt_ext_o),
    .evt_brk_o  (evt_brk_o)
  );

  p_prefix_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && byte_i[BIT_TOP] |=> !evt_vld_o);
  p_pulse_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld_o |-> $past(byte_vld_i));
endmodule

// File: tb/kbd_seq_decoder_tb.sv
`timescale 1ns/1ps
module kbd_seq_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       byte_vld = 1'b0;
  logic       evt_vld, evt_ext, evt_brk;
  logic [7:0] evt_code;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  kbd_seq_decoder u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .byte_i     (byte_in),
    .byte_vld_i (byte_vld),
    .evt_vld_o  (evt_vld),
    .evt_code_o (evt_code),
    .evt_ext_o  (evt_ext),
    .evt_brk_o  (evt_brk)
  );

  // {byte, exp_vld, exp_ext, exp_brk, req}
  localparam int NV = 26;
  localparam logic [14:0] VEC [NV] = '{
    {8'h1C, 3'b100, 4'd2},
    {8'hF0, 3'b000, 4'd7}, {8'h1C, 3'b101, 4'd3},
    {8'hE0, 3'b000, 4'd7}, {8'h14, 3'b110, 4'd4},
    {8'hE0, 3'b000, 4'd7}, {8'hF0, 3'b000, 4'd7}, {8'h14, 3'b111, 4'd4},
    {8'hE0, 3'b000, 4'd7}, {8'h7C, 3'b110, 4'd4},
    {8'hE1, 3'b000, 4'd7}, {8'h14, 3'b000, 4'd5}, {8'h77, 3'b110, 4'd5},
    {8'hE1, 3'b000, 4'd7}, {8'hF0, 3'b000, 4'd7}, {8'h14, 3'b000, 4'd6},
    {8'hF0, 3'b000, 4'd7}, {8'h77, 3'b111, 4'd6},
    {8'h83, 3'b000, 4'd9}, {8'h2B, 3'b100, 4'd9},
    {8'hE0, 3'b000, 4'd7}, {8'h83, 3'b000, 4'd9}, {8'h75, 3'b110, 4'd9},
    {8'hF0, 3'b000, 4'd7}, {8'h83, 3'b000, 4'd9}, {8'h1C, 3'b100, 4'd9}
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_in  = b;
    byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic chk_evt(input string req, input logic v, input logic [7:0] c,
                         input logic x, input logic k);
    chk(req, "evt_vld", {7'd0, evt_vld}, {7'd0, v});
    if (v) begin
      chk(req, "evt_code", evt_code, c);
      chk(req, "evt_ext", {7'd0, evt_ext}, {7'd0, x});
      chk(req, "evt_brk", {7'd0, evt_brk}, {7'd0, k});
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "evt_vld in reset", {7'd0, evt_vld}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "evt_vld after reset", {7'd0, evt_vld}, 8'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][14:7]);
      chk_evt(rname(VEC[i][3:0]), VEC[i][6], VEC[i][14:7], VEC[i][5], VEC[i][4]);
      if (VEC[i][6]) begin
        @(negedge clk);
        chk("R10", "strobe width", {7'd0, evt_vld}, 8'd0);
      end
    end

    // R8: byte without strobe is ignored
    @(negedge clk);
    byte_in = 8'hF0; byte_vld = 1'b0;
    @(negedge clk);
    chk("R8", "no event on unstrobed byte", {7'd0, evt_vld}, 8'd0);
    send(8'h1C);
    chk_evt("R8", 1'b1, 8'h1C, 1'b0, 1'b0);

    // R10: back-to-back bytes, release then key then key
    @(negedge clk);
    byte_in = 8'hF0; byte_vld = 1'b1;
    @(negedge clk);
    byte_in = 8'h23;
    @(negedge clk);
    byte_in = 8'h24;
    chk_evt("R10", 1'b1, 8'h23, 1'b0, 1'b1);
    @(negedge clk);
    byte_vld = 1'b0;
    chk_evt("R10", 1'b1, 8'h24, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10", "strobe drops", {7'd0, evt_vld}, 8'd0);

    // R1: reset mid-sequence returns to idle
    send(8'hE0);
    send(8'hF0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "evt_vld in reset", {7'd0, evt_vld}, 8'd0);
    chk("R1", "code cleared", evt_code, 8'd0);
    rst_n = 1'b1;
    send(8'h1C);
    chk_evt("R1", 1'b1, 8'h1C, 1'b0, 1'b0);

    // R7: other hi bytes stay silent
    send(8'hE1);
    chk("R7", "E1 silent", {7'd0, evt_vld}, 8'd0);
    send(8'h14);
    chk("R5", "skipped byte silent", {7'd0, evt_vld}, 8'd0);
    send(8'h5A);
    chk_evt("R5", 1'b1, 8'h5A, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule